// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial bus (I2C-style) placed in front of a byte-wide memory of 32768 locations. It samples the bus clock and data lines on a fast system clock and finds start and stop conditions from them. It then shifts in a device selection byte and acknowledges it only when the fixed pattern and the two strap inputs match. After a match, it either takes a two-byte word address followed by data bytes and writes them to the array, or returns array bytes to the master.

One address counter holds its value from one transaction to the next. Three kinds of read use it:
- a current-address read;
- a random read, which is an address-only write followed by a repeated start;
- a sequential read, which continues for as long as the master acknowledges each byte.

A stop that ends a transaction containing write data starts a self-timed busy period. During that period the block ignores the bus and acknowledges nothing. A master can therefore poll with start plus selection byte until it gets an acknowledge. The array is modelled by an external synchronous RAM port, and read data is valid one cycle after the read strobe.

Top module: `ee2w_slave`

## Requirements
- R1: A selection byte, shifted in MSB first after a start, is acknowledged when it matches all of the following. Bits 7:4 must be 1010, bit 3 must be 0, and bits 2:1 must equal `dev_sel[1:0]`. Bit 0 selects read (1) or write (0). The acknowledge is SDA held low for the whole ninth SCL high phase.
- R2: A selection byte that does not match gets no acknowledge (SDA stays high). Every later byte up to the next start is also left unacknowledged, and no memory strobe is issued.
- R3: In a write, the first byte after the selection byte supplies address bits 14:8 (in its bits 6:0), and the second byte supplies address bits 7:0. Each following data byte is acknowledged and written to the current address with one `mem_we` pulse.
- R4: During a write, only address bits 5:0 advance after each data byte. A byte after the last location of a 64-byte page lands at the first location of the same page.
- R5: A stop after at least one written data byte holds the block busy for exactly BUSY_CYCLES clocks. While busy, no selection byte is acknowledged and no memory strobe is issued.
- R6: After the busy period ends, a start plus matching selection byte is acknowledged again (acknowledge polling).
- R7: A read without a preceding address phase returns the byte at the address one past the last accessed byte. The counter keeps its value across transactions.
- R8: An address-only write followed by a repeated start and a read selection byte returns the byte at the address just given.
- R9: A read continues with the next byte while the master drives SDA low in the ninth clock. A high in the ninth clock ends the read and releases SDA. Read addresses advance across all 15 bits and wrap from 0x7FFF to 0x0000.
- R10: The block changes its SDA drive only while SCL is low.
- R11: During reset SDA is released and both memory strobes are low. The first read after reset returns address 0.
- R12: A stop after a write transaction that carried no data byte does not start a busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| dev_sel | input | 2 | Strapped device select bits compared with selection bits 2:1 |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain drive) |
| mem_re | output | 1 | Array read strobe; data valid next cycle |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array address for both strobes |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data |

## Verification
The end of the busy period and the arrival of a polling start can fall into the same cycle. The start is accepted only if the timer has already dropped. The bench provokes this by polling back to back right after a page write. It then judges three things: the first poll is refused, a later poll is acknowledged, and a checker confirms that the busy run lasted exactly the configured count. A second overlap comes from a data byte's memory write and the start of its acknowledge, which are launched in the same decision cycle. This is judged through the acknowledge seen on the bus and the array contents after page wrap.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

  // Transfer phase of the slave engine
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_t;

  // Meaning of the byte being received
  typedef enum logic [1:0] {
    RL_DEV,
    RL_AHI,
    RL_ALO,
    RL_DATA
  } role_t;

  localparam logic [3:0] SEL_TAG = 4'b1010;

  function automatic role_t role_after(input role_t r);
    unique case (r)
      RL_DEV:  return RL_AHI;
      RL_AHI:  return RL_ALO;
      default: return RL_DATA;
    endcase
  endfunction

endpackage

// File: rtl/ee2w_line_sync.sv
module ee2w_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh_q, sda_sh_q;
  logic              scl_prev_q, sda_prev_q;
  logic              scl_now, sda_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q   <= '1;
      sda_sh_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sh_q   <= {scl_sh_q[STAGES-2:0], scl_in};
      sda_sh_q   <= {sda_sh_q[STAGES-2:0], sda_in};
      scl_prev_q <= scl_sh_q[STAGES-1];
      sda_prev_q <= sda_sh_q[STAGES-1];
    end
  end

  assign scl_now   = scl_sh_q[STAGES-1];
  assign sda_now   = sda_sh_q[STAGES-1];
  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_prev_q;
  assign scl_fall  = ~scl_now & scl_prev_q;
  assign start_det = scl_now & scl_prev_q & sda_prev_q & ~sda_now;
  assign stop_det  = scl_now & scl_prev_q & ~sda_prev_q & sda_now;
endmodule

// File: rtl/ee2w_busy_timer.sv
module ee2w_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (launch)             cnt_d = CW'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/ee2w_ctrl.sv
module ee2w_ctrl
  import ee2w_pkg::*;
#(
  parameter int unsigned AW        = 15,
  parameter int unsigned PAGE_BITS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          busy,
  input  logic [1:0]    dev_sel,
  input  logic [7:0]    mem_rdata,
  output logic          sda_pull,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          launch
);
  localparam int unsigned HI_W = AW - 8;

  phase_t        phase_q, phase_d;
  role_t         role_q, role_d;
  logic [3:0]    bitcnt_q, bitcnt_d;
  logic [7:0]    shreg_q, shreg_d;
  logic [7:0]    rdbuf_q, rdbuf_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          rw_q, rw_d;
  logic          pull_q, pull_d;
  logic          wrpend_q, wrpend_d;
  logic          more_q, more_d;
  logic          rdv_q, rdv_d;
  logic          sel_hit;

  assign sel_hit = (shreg_q[7:4] == SEL_TAG) && !shreg_q[3] &&
                   (shreg_q[2:1] == dev_sel);

  always_comb begin
    phase_d  = phase_q;
    role_d   = role_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    hi_d     = hi_q;
    addr_d   = addr_q;
    rw_d     = rw_q;
    pull_d   = pull_q;
    wrpend_d = wrpend_q;
    more_d   = more_q;
    rdv_d    = 1'b0;
    rdbuf_d  = rdv_q ? mem_rdata : rdbuf_q;
    mem_re   = 1'b0;
    mem_we   = 1'b0;
    launch   = 1'b0;

    if (stop_det) begin
      phase_d = PH_IDLE;
      pull_d  = 1'b0;
      more_d  = 1'b0;
      if (wrpend_q) begin
        launch   = 1'b1;
        wrpend_d = 1'b0;
      end
    end else if (start_det && !busy) begin
      phase_d  = PH_RX;
      role_d   = RL_DEV;
      bitcnt_d = '0;
      pull_d   = 1'b0;
      more_d   = 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
        end
        PH_RX: begin
          if (scl_rise && bitcnt_q != 4'd8) begin
            shreg_d  = {shreg_q[6:0], sda_lvl};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            phase_d = PH_ACK;
            pull_d  = 1'b1;
            unique case (role_q)
              RL_DEV: begin
                if (sel_hit) begin
                  rw_d = shreg_q[0];
                  if (shreg_q[0]) begin
                    mem_re = 1'b1;
                    rdv_d  = 1'b1;
                    addr_d = addr_q + AW'(1);
                  end
                end else begin
                  phase_d = PH_IDLE;
                  pull_d  = 1'b0;
                end
              end
              RL_AHI: hi_d = shreg_q[HI_W-1:0];
              RL_ALO: addr_d = {hi_q, shreg_q};
              default: begin
                mem_we   = 1'b1;
                wrpend_d = 1'b1;
                addr_d   = {addr_q[AW-1:PAGE_BITS],
                            addr_q[PAGE_BITS-1:0] + PAGE_BITS'(1)};
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            if (role_q == RL_DEV && rw_q) begin
              phase_d = PH_TX;
              shreg_d = rdbuf_q;
              pull_d  = ~rdbuf_q[7];
            end else begin
              phase_d = PH_RX;
              pull_d  = 1'b0;
              role_d  = role_after(role_q);
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              phase_d = PH_MACK;
              pull_d  = 1'b0;
            end else begin
              shreg_d  = {shreg_q[6:0], 1'b0};
              pull_d   = ~shreg_q[6];
              bitcnt_d = bitcnt_q + 4'd1;
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            if (!sda_lvl) begin
              mem_re = 1'b1;
              rdv_d  = 1'b1;
              more_d = 1'b1;
              addr_d = addr_q + AW'(1);
            end else begin
              phase_d = PH_IDLE;
            end
          end else if (scl_fall && more_q) begin
            phase_d  = PH_TX;
            shreg_d  = rdbuf_q;
            pull_d   = ~rdbuf_q[7];
            bitcnt_d = '0;
            more_d   = 1'b0;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      role_q   <= RL_DEV;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      rdbuf_q  <= '0;
      hi_q     <= '0;
      addr_q   <= '0;
      rw_q     <= 1'b0;
      pull_q   <= 1'b0;
      wrpend_q <= 1'b0;
      more_q   <= 1'b0;
      rdv_q    <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      role_q   <= role_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      rdbuf_q  <= rdbuf_d;
      hi_q     <= hi_d;
      addr_q   <= addr_d;
      rw_q     <= rw_d;
      pull_q   <= pull_d;
      wrpend_q <= wrpend_d;
      more_q   <= more_d;
      rdv_q    <= rdv_d;
    end
  end

  assign sda_pull  = pull_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = shreg_q;
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave #(
  parameter int unsigned AW          = 15,
  parameter int unsigned PAGE_BITS   = 6,
  parameter int unsigned BUSY_CYCLES = 250000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [1:0]    dev_sel,
  output logic          sda_pull,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic       launch_w, busy_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  ee2w_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  ee2w_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .launch (launch_w),
    .busy   (busy_w)
  );

  ee2w_ctrl #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .busy      (busy_w),
    .dev_sel   (dev_sel),
    .mem_rdata (mem_rdata),
    .sda_pull  (sda_pull),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .launch    (launch_w)
  );
endmodule

// File: rtl/ee2w_slave_chk.sv
module ee2w_slave_chk #(
  parameter int unsigned BUSY_CYCLES = 250000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_pull,
  input logic mem_we,
  input logic mem_re,
  input logic busy
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  // R11: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R11: assert (!sda_pull && !mem_we && !mem_re);
    end
  end

  // R10: drive changes only with SCL low
  assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_in);

  // R5: nothing happens on bus or array while busy
  assert_busy_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!sda_pull && !mem_we && !mem_re));

  // R5: busy run lasts exactly the configured count
  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == BUSY_CYCLES));

  // R3: strobes never overlap
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));

  // R3: every array write is followed by an acknowledge drive
  assert_write_acked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sda_pull);
endmodule

bind ee2w_slave ee2w_slave_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_in   (scl_in),
  .sda_pull (sda_pull),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .busy     (busy_w)
);

// File: tb/ee2w_slave_bench.sv
`timescale 1ns/1ps
module ee2w_slave_bench;
  localparam int H    = 8;
  localparam int Q    = 2;
  localparam int BUSY = 400;

  // {selection byte, expected acknowledge}, dev_sel = 2'b10
  localparam logic [8:0] SEL_TAB [8] = '{
    {8'hA4, 1'b1}, {8'hA5, 1'b1}, {8'hA0, 1'b0}, {8'hA6, 1'b0},
    {8'hAC, 1'b0}, {8'hB4, 1'b0}, {8'h24, 1'b0}, {8'hA2, 1'b0}
  };

  logic        clk, rst_n, scl_m, sda_m, sda_line;
  logic        sda_pull, mem_re, mem_we;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  ram [0:1023];
  int          n_chk, n_err, we_cnt, r10_viol, cyc;
  logic        pull_prev;

  assign sda_line = sda_m & ~sda_pull;

  ee2w_slave #(.BUSY_CYCLES(BUSY)) u_ee2w_slave (
    .clk (clk), .rst_n (rst_n), .scl_in (scl_m), .sda_in (sda_line),
    .dev_sel (2'b10), .sda_pull (sda_pull), .mem_re (mem_re), .mem_we (mem_we),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [9:0] a);
    return a[7:0] ^ {6'b0, a[9:8]} ^ 8'hC3;
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) ram[i] = pat(10'(i));
  end

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr[9:0]];
  end

  always @(posedge clk) begin
    if (mem_we) we_cnt <= we_cnt + 1;
    if (rst_n && sda_pull != pull_prev && scl_m) r10_viol <= r10_viol + 1;
    pull_prev <= sda_pull;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk = n_chk + 1;
      n_err = n_err + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(H - Q);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(H - Q);
      scl_m = 1'b1; wait_clk(H);
      scl_m = 1'b0; wait_clk(Q);
    end
    sda_m = 1'b1; wait_clk(H - Q);
    scl_m = 1'b1; wait_clk(H / 2);
    ack = !sda_line; wait_clk(H / 2);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(H - Q);
      scl_m = 1'b1; wait_clk(H / 2);
      b[i] = sda_line; wait_clk(H / 2);
      scl_m = 1'b0; wait_clk(Q);
    end
    sda_m = mack ? 1'b0 : 1'b1; wait_clk(H - Q);
    scl_m = 1'b1; wait_clk(H);
    scl_m = 1'b0; wait_clk(Q);
    sda_m = 1'b1;
  endtask

  task automatic cur_read(output logic [7:0] b, output bit ack);
    bus_start();
    send_byte(8'hA5, ack);
    if (ack) recv_byte(b, 1'b0);
    else b = 8'h00;
    bus_stop();
  endtask

  initial begin
    bit         ack;
    logic [7:0] d;
    int         polls;
    int         we_before;
    n_chk = 0; n_err = 0; we_cnt = 0; r10_viol = 0; cyc = 0;
    pull_prev = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    wait_clk(5);
    // R11: quiet during reset
    chk(sda_pull == 1'b0, "R11 sda released in reset", sda_pull, 0);
    chk(mem_we == 1'b0 && mem_re == 1'b0, "R11 strobes low in reset", {mem_we, mem_re}, 0);
    rst_n = 1'b1;
    wait_clk(10);
    // R11: first read after reset starts at address 0
    cur_read(d, ack);
    chk(ack && d == pat(10'h000), "R11 first read", d, pat(10'h000));

    // R1 / R2: selection byte table
    for (int k = 0; k < 8; k++) begin
      bus_start();
      send_byte(SEL_TAB[k][8:1], ack);
      chk(ack == SEL_TAB[k][0], SEL_TAB[k][0] ? "R1 match ack" : "R2 mismatch nack",
          ack, SEL_TAB[k][0]);
      if (ack && SEL_TAB[k][1]) begin
        recv_byte(d, 1'b0);
        chk(d == pat(10'h001), "R7 read in table", d, pat(10'h001));
      end
      bus_stop();
      wait_clk(H);
    end

    // R2: after mismatch the rest of the transfer is ignored
    we_before = we_cnt;
    bus_start();
    send_byte(8'hA0, ack);
    chk(!ack, "R2 mismatch", ack, 0);
    send_byte(8'h12, ack);
    chk(!ack, "R2 follow byte ignored", ack, 0);
    send_byte(8'h34, ack);
    chk(!ack, "R2 second follow byte ignored", ack, 0);
    bus_stop();
    chk(we_cnt == we_before, "R2 no writes", we_cnt, we_before);

    // R3 / R4: page write across the page end
    bus_start();
    send_byte(8'hA4, ack); chk(ack, "R3 sel ack", ack, 1);
    send_byte(8'h01, ack); chk(ack, "R3 addr hi ack", ack, 1);
    send_byte(8'h3E, ack); chk(ack, "R3 addr lo ack", ack, 1);
    for (int j = 0; j < 4; j++) begin
      send_byte(8'hD0 + 8'(j), ack);
      chk(ack, "R3 data ack", ack, 1);
    end
    bus_stop();
    chk(ram[10'h13E] == 8'hD0, "R3 byte at 0x13E", ram[10'h13E], 8'hD0);
    chk(ram[10'h13F] == 8'hD1, "R3 byte at 0x13F", ram[10'h13F], 8'hD1);
    chk(ram[10'h100] == 8'hD2, "R4 wrap to page start", ram[10'h100], 8'hD2);
    chk(ram[10'h101] == 8'hD3, "R4 second wrapped byte", ram[10'h101], 8'hD3);
    chk(ram[10'h140] == pat(10'h140), "R4 next page untouched", ram[10'h140], pat(10'h140));

    // R5: busy right after the write
    we_before = we_cnt;
    bus_start();
    send_byte(8'hA4, ack);
    chk(!ack, "R5 no ack while busy", ack, 0);
    bus_stop();
    chk(we_cnt == we_before, "R5 no writes while busy", we_cnt, we_before);

    // R6: acknowledge polling
    polls = 1;
    ack = 1'b0;
    for (int p = 0; p < 30 && !ack; p++) begin
      bus_start();
      send_byte(8'hA4, ack);
      polls++;
      if (!ack) bus_stop();
    end
    chk(ack && polls > 2, "R6 poll eventually acked", polls, 3);
    bus_stop();
    // R12: address-only write leaves no busy period
    bus_start();
    send_byte(8'hA4, ack);
    chk(ack, "R12 no busy after empty write", ack, 1);
    bus_stop();

    // R7: current-address reads continue after page write
    cur_read(d, ack);
    chk(ack && d == pat(10'h102), "R7 current read", d, pat(10'h102));
    cur_read(d, ack);
    chk(ack && d == pat(10'h103), "R7 counter persists", d, pat(10'h103));

    // R8 / R9: random read at 0x7FFE then sequential across the top
    bus_start();
    send_byte(8'hA4, ack);
    send_byte(8'h7F, ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte(8'hA5, ack);
    chk(ack, "R8 read sel after restart", ack, 1);
    recv_byte(d, 1'b1);
    chk(d == pat(10'h3FE), "R8 random read", d, pat(10'h3FE));
    recv_byte(d, 1'b1);
    chk(d == pat(10'h3FF), "R9 sequential next", d, pat(10'h3FF));
    recv_byte(d, 1'b0);
    chk(d == pat(10'h000), "R9 wrap to zero", d, pat(10'h000));
    wait_clk(H);
    chk(sda_line == 1'b1, "R9 released after nack", sda_line, 1);
    bus_stop();
    cur_read(d, ack);
    chk(ack && d == pat(10'h001), "R9 counter after wrap", d, pat(10'h001));

    chk(r10_viol == 0, "R10 drive change with SCL high", r10_viol, 0);
    summary();
    $finish;
  end
endmodule